// File: doc/BRIEF.md
# Bus Error Monitor and Machine-Check Reporter

This block observes a shared processor bus and turns protocol and integrity failures into machine-check activity. Two watchdogs run side by side. One measures how long the priority bus request line stays asserted and raises a protocol-violation flag when that time exceeds a programmable limit. The other measures how long an issued transaction waits for its response. When that wait runs past its own limit, the block acts as the central agent: it claims the transaction and signals that it ends with a hard-error response.

Error strobes from the external parity and ECC checkers and the target's hard-error response join the two timeout events. When the machine-check enable input is set, each error becomes one log write carrying a source code. Several errors in one cycle are written one per cycle, lowest code first. The excess is held in a small queue. Hard-error responses from either the target or the central agent are unrecoverable, and they raise a one-cycle machine-check exception request. That request is withheld while a machine check is already in progress, and when this part serves as the checker of a redundant pair.

Top module: `bus_err_mca`

## Requirements
- R1: When `prio_req` is high for `arb_limit`+1 consecutive cycles, `proto_viol` is high for exactly the one cycle following the edge that samples the last of those cycles. It fires once per assertion. The count starts again from zero after `prio_req` drops, and a limit of 0 fires on the first asserted cycle.
- R2: When `txn_wait` is high for `rsp_limit`+1 consecutive cycles, `ca_hard_rsp` pulses for one cycle with the same timing as R1. It fires once per transaction.
- R3: With `mc_enable` high, every error produces one `log_we` cycle, with `log_code` naming its source: arbitration timeout = 0, response timeout = 1, hard-error response (`tgt_hard_err`) = 2, parity = 3, ECC = 4. An error alone in a cycle with an empty queue is written in the cycle after the edge that samples it.
- R4: Errors in one cycle are written on successive cycles, lowest code first. Errors from later cycles follow all earlier ones. At most one write occurs per cycle.
- R5: While `mc_enable` is low, no new error is recorded, entries already queued are discarded, `log_we` stays low and `mc_req` stays low.
- R6: With `mc_enable` high, a response timeout or target hard-error response makes `mc_req` high for one cycle, the cycle after the edge that samples the error. Arbitration timeouts, parity errors and ECC errors never raise `mc_req`.
- R7: No `mc_req` is raised for an error sampled while `mc_active` is high. The error is still logged.
- R8: No `mc_req` is raised for an error sampled while `checker_role` is high. The error is still logged.
- R9: `mc_req` is never high on two consecutive cycles. An unrecoverable error sampled at the edge that ends a pulse does not raise a second one.
- R10: After reset, `proto_viol`, `ca_hard_rsp`, `log_we` and `mc_req` are all low.
- R11: `proto_viol` and `ca_hard_rsp` work the same whether `mc_enable` is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_enable | input | 1 | Machine-check logging and exception enable |
| mc_active | input | 1 | A machine check is already being handled |
| checker_role | input | 1 | Part is the checker of a redundant pair |
| arb_limit | input | CNT_W | Allowed cycles of priority request before violation |
| rsp_limit | input | CNT_W | Allowed cycles of response wait before claim |
| prio_req | input | 1 | Priority bus request line, active high |
| txn_wait | input | 1 | A transaction is waiting for its response |
| tgt_hard_err | input | 1 | Target gives a hard-error response this cycle |
| parity_err | input | 1 | Parity checker reports an error this cycle |
| ecc_err | input | 1 | ECC checker reports an error this cycle |
| proto_viol | output | 1 | Bus protocol violation pulse |
| ca_hard_rsp | output | 1 | Central agent claims the transaction with a hard error |
| log_we | output | 1 | Log write strobe |
| log_code | output | 3 | Source code of the logged error |
| mc_req | output | 1 | Machine-check exception request pulse |

## Verification
The arbitration watchdog and the response watchdog can expire in the same cycle. The bench provokes this by setting both limits equal and raising `prio_req` and `txn_wait` on the same cycle. It then expects both flags to pulse together, log codes 0 and 1 on two successive cycles, and a single exception request. A hard-error response together with parity and ECC strobes in one cycle is also checked, followed by a second burst on the next cycle, to confirm both ordering within a cycle and ordering across cycles. A behavioural model built on counters and a code queue predicts every output each cycle.

// File: rtl/bem_pkg.sv
package bem_pkg;
    localparam int NSRC   = 5;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        SRC_ARB  = 3'd0,
        SRC_RSP  = 3'd1,
        SRC_HARD = 3'd2,
        SRC_PAR  = 3'd3,
        SRC_ECC  = 3'd4
    } src_e;

    typedef logic [NSRC-1:0] src_mask_t;

    // Sources classed as unrecoverable: response timeout and hard-error response.
    localparam src_mask_t UNREC_MASK = src_mask_t'((1 << SRC_RSP) | (1 << SRC_HARD));

    function automatic logic [CODE_W-1:0] low_idx(input src_mask_t m);
        logic [CODE_W-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (m[i]) r = CODE_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/bem_watchdog.sv
module bem_watchdog #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hit;
    } wd_t;

    wd_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        fire = act && (s_q.cnt == limit) && !s_q.hit;
        if (!act) begin
            s_d.cnt = '0;
            s_d.hit = 1'b0;
        end else begin
            if (s_q.cnt != limit) s_d.cnt = s_q.cnt + 1'b1;
            s_d.hit = s_q.hit | fire;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1 / R2: an expiry reports once per continuous assertion
    p_fire_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    // R1 / R2: an idle line leaves the watchdog cleared
    p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (s_q.cnt == '0) && !s_q.hit);
endmodule

// File: rtl/bem_log_queue.sv
module bem_log_queue
    import bem_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  src_mask_t         new_mask,
    output logic              log_we,
    output logic [CODE_W-1:0] log_code
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][NSRC-1:0] mem;
        logic [PW-1:0]              wp;
        logic [PW-1:0]              rp;
        logic [CW-1:0]              cnt;
        src_mask_t                  cur;
        logic                       we;
        logic [CODE_W-1:0]          code;
    } lq_t;

    lq_t       s_d, s_q;
    src_mask_t src;
    logic      pop, push, take_new;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d      = s_q;
        s_d.we   = 1'b0;
        src      = '0;
        pop      = 1'b0;
        push     = 1'b0;
        take_new = 1'b0;
        if (!en) begin
            s_d.cur = '0;
            s_d.cnt = '0;
            s_d.wp  = '0;
            s_d.rp  = '0;
        end else begin
            // Oldest pending work first: partly drained mask, queue head, then new
            if (s_q.cur != '0) begin
                src = s_q.cur;
            end else if (s_q.cnt != '0) begin
                src = s_q.mem[s_q.rp];
                pop = 1'b1;
            end else begin
                src      = new_mask;
                take_new = 1'b1;
            end
            s_d.cur = src & src_mask_t'(src - 1'b1);
            if (src != '0) begin
                s_d.we   = 1'b1;
                s_d.code = low_idx(src);
            end
            push = (new_mask != '0) && !take_new && ((s_q.cnt != CW'(DEPTH)) || pop);
            if (pop) s_d.rp = nxt(s_q.rp);
            if (push) begin
                s_d.mem[s_q.wp] = new_mask;
                s_d.wp          = nxt(s_q.wp);
            end
            case ({push, pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign log_we   = s_q.we;
    assign log_code = s_q.code;

    p_off_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !log_we);
    p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        log_we |-> (log_code <= CODE_W'(NSRC - 1)));
    p_one_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pop, take_new, s_q.cur != '0}));
endmodule

// File: rtl/bem_mc_gate.sv
module bem_mc_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic unrec,
    input  logic en,
    input  logic busy,
    input  logic chk,
    output logic req
);
    typedef struct packed {
        logic req;
    } mg_t;

    mg_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        // Own pulse counts as "in progress" until the handler flag arrives
        s_d.req = unrec && en && !busy && !chk && !s_q.req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req = s_q.req;

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !req);
    p_checker_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chk |=> !req);
    p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !req);
    p_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !unrec |=> !req);
endmodule

// File: rtl/bus_err_mca.sv
module bus_err_mca
    import bem_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int LOG_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_enable,
    input  logic              mc_active,
    input  logic              checker_role,
    input  logic [CNT_W-1:0]  arb_limit,
    input  logic [CNT_W-1:0]  rsp_limit,
    input  logic              prio_req,
    input  logic              txn_wait,
    input  logic              tgt_hard_err,
    input  logic              parity_err,
    input  logic              ecc_err,
    output logic              proto_viol,
    output logic              ca_hard_rsp,
    output logic              log_we,
    output logic [CODE_W-1:0] log_code,
    output logic              mc_req
);
    localparam int NWD = 2;

    typedef struct packed {
        logic pv;
        logic ca;
    } fl_t;

    logic [NWD-1:0]            wd_act;
    logic [NWD-1:0][CNT_W-1:0] wd_lim;
    logic [NWD-1:0]            wd_fire;
    src_mask_t                 err_mask;
    logic                      unrec;
    fl_t                       f_d, f_q;

    assign wd_act = {txn_wait, prio_req};
    assign wd_lim = {rsp_limit, arb_limit};

    // Index 0 is the arbitration watchdog, index 1 the response watchdog
    for (genvar g = 0; g < NWD; g++) begin : g_wd
        bem_watchdog #(.CNT_W(CNT_W)) u_wd (
            .clk   (clk),
            .rst_n (rst_n),
            .act   (wd_act[g]),
            .limit (wd_lim[g]),
            .fire  (wd_fire[g])
        );
    end

    always_comb begin
        err_mask           = '0;
        err_mask[SRC_ARB]  = wd_fire[0];
        err_mask[SRC_RSP]  = wd_fire[1];
        err_mask[SRC_HARD] = tgt_hard_err;
        err_mask[SRC_PAR]  = parity_err;
        err_mask[SRC_ECC]  = ecc_err;
        unrec              = |(err_mask & UNREC_MASK);
        f_d                = f_q;
        f_d.pv             = wd_fire[0];
        f_d.ca             = wd_fire[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign proto_viol  = f_q.pv;
    assign ca_hard_rsp = f_q.ca;

    bem_log_queue #(.DEPTH(LOG_DEPTH)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mc_enable),
        .new_mask (err_mask),
        .log_we   (log_we),
        .log_code (log_code)
    );

    bem_mc_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .unrec (unrec),
        .en    (mc_enable),
        .busy  (mc_active),
        .chk   (checker_role),
        .req   (mc_req)
    );

    p_flag_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        proto_viol |=> !proto_viol);
    p_claim_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ca_hard_rsp |=> !ca_hard_rsp);
    p_claim_needs_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_wait |=> !ca_hard_rsp);
endmodule

// File: tb/tb_bus_err_mca.sv
module tb_bus_err_mca;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_enable = 1'b0, mc_active = 1'b0, checker_role = 1'b0;
    logic [7:0] arb_limit = 8'd3, rsp_limit = 8'd5;
    logic       prio_req = 1'b0, txn_wait = 1'b0, tgt_hard_err = 1'b0;
    logic       parity_err = 1'b0, ecc_err = 1'b0;
    logic       proto_viol, ca_hard_rsp, log_we, mc_req;
    logic [2:0] log_code;

    always #2 clk = ~clk;

    bus_err_mca dut (
        .clk(clk), .rst_n(rst_n), .mc_enable(mc_enable), .mc_active(mc_active),
        .checker_role(checker_role), .arb_limit(arb_limit), .rsp_limit(rsp_limit),
        .prio_req(prio_req), .txn_wait(txn_wait), .tgt_hard_err(tgt_hard_err),
        .parity_err(parity_err), .ecc_err(ecc_err), .proto_viol(proto_viol),
        .ca_hard_rsp(ca_hard_rsp), .log_we(log_we), .log_code(log_code), .mc_req(mc_req)
    );

    int  n_chk = 0, n_bad = 0;
    int  arb_run = 0, rsp_run = 0, busy_arm = 0;
    int  q[$];
    bit  e_pv = 0, e_ca = 0, e_we = 0, e_req = 0;
    int  e_code = 0;
    bit  en_v = 0, chk_v = 0, busy_v = 0;
    bit  done = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive inputs, predict, cross the edge, compare every output.
    task automatic step(input string tag, input bit pr, input bit tw, input bit he,
                        input bit pe, input bit ee);
        bit af, rf, unrec, nreq;
        if (busy_arm > 0) begin
            busy_arm--;
            if (busy_arm == 0) busy_v = 1;
        end
        prio_req = pr; txn_wait = tw; tgt_hard_err = he; parity_err = pe; ecc_err = ee;
        mc_enable = en_v; checker_role = chk_v; mc_active = busy_v;
        af = 0; rf = 0;
        if (pr) begin arb_run++; if (arb_run == int'(arb_limit) + 1) af = 1; end
        else arb_run = 0;
        if (tw) begin rsp_run++; if (rsp_run == int'(rsp_limit) + 1) rf = 1; end
        else rsp_run = 0;
        if (!en_v) q.delete();
        else begin
            if (af) q.push_back(0);
            if (rf) q.push_back(1);
            if (he) q.push_back(2);
            if (pe) q.push_back(3);
            if (ee) q.push_back(4);
        end
        e_we = en_v && (q.size() > 0);
        if (e_we) e_code = q.pop_front();
        unrec = rf || he;
        nreq  = unrec && en_v && !busy_v && !chk_v && !e_req;
        e_pv = af; e_ca = rf; e_req = nreq;
        if (nreq) busy_arm = 2;   // handler flag appears one cycle after the pulse
        @(posedge clk);
        #1;
        check(tag, "R1 proto_viol", int'(proto_viol), int'(e_pv));
        check(tag, "R2 ca_hard_rsp", int'(ca_hard_rsp), int'(e_ca));
        check(tag, "R3 log_we", int'(log_we), int'(e_we));
        if (e_we) check(tag, "R4 log_code", int'(log_code), e_code);
        check(tag, "R6 mc_req", int'(mc_req), int'(e_req));
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(4 * 50000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10", "proto_viol", int'(proto_viol), 0);
        check("R10", "ca_hard_rsp", int'(ca_hard_rsp), 0);
        check("R10", "log_we", int'(log_we), 0);
        check("R10", "mc_req", int'(mc_req), 0);
        @(negedge clk);
        en_v = 1;

        // R1: long request, restart after a gap, then a zero limit
        for (int i = 0; i < 6; i++) step("R1", 1, 0, 0, 0, 0);
        step("R1", 0, 0, 0, 0, 0);
        step("R1", 1, 0, 0, 0, 0); step("R1", 1, 0, 0, 0, 0);
        step("R1", 0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) step("R1", 1, 0, 0, 0, 0);
        idle("R1", 2);
        arb_limit = 8'd0;
        step("R1", 1, 0, 0, 0, 0); step("R1", 1, 0, 0, 0, 0);
        idle("R1", 2);
        arb_limit = 8'd3;

        // R2: response timeout claims and raises the exception
        for (int i = 0; i < 8; i++) step("R2", 0, 1, 0, 0, 0);
        idle("R2", 3);
        busy_v = 0;

        // R3: each source alone
        step("R3", 0, 0, 1, 0, 0); idle("R3", 3); busy_v = 0;
        step("R3", 0, 0, 0, 1, 0); idle("R3", 1);
        step("R3", 0, 0, 0, 0, 1); idle("R3", 1);

        // R4: same-cycle burst then a second burst
        step("R4", 0, 0, 1, 1, 1);
        step("R4", 0, 0, 0, 1, 1);
        idle("R4", 6); busy_v = 0;

        // Both watchdogs expire together (codes 0 then 1)
        rsp_limit = 8'd3;
        for (int i = 0; i < 4; i++) step("R4", 1, 1, 0, 0, 0);
        idle("R4", 4); busy_v = 0;
        rsp_limit = 8'd5;

        // R7: in-progress suppresses the request but not the log
        busy_v = 1;
        step("R7", 0, 0, 1, 0, 0); idle("R7", 2);
        busy_v = 0;

        // R8: checker role suppresses the request
        chk_v = 1;
        step("R8", 0, 0, 1, 0, 0); idle("R8", 2);
        chk_v = 0;

        // R9: back-to-back unrecoverable errors give one pulse
        step("R9", 0, 0, 1, 0, 0); step("R9", 0, 0, 1, 0, 0);
        idle("R9", 4); busy_v = 0;

        // R5: disable mid-drain, then errors while disabled
        step("R5", 0, 0, 1, 1, 1);
        en_v = 0;
        step("R5", 0, 0, 1, 1, 0);
        idle("R5", 2);
        // R11: timeout flags still work with logging disabled
        for (int i = 0; i < 7; i++) step("R11", 1, 1, 0, 0, 0);
        idle("R11", 2);
        en_v = 1;
        idle("R5", 2);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule